// File: doc/BRIEF.md
# Five-Decade Decimal Event Counter with First-Stage Modes

This block counts rising edges of an external count clock in five cascaded decimal stages: units, tens, hundreds, thousands and ten-thousands. Each stage holds a value from 0 to 9. The count clock is brought into the system clock domain by a two-flop synchroniser, and a one-flop edge detector finds its rising edge. Every state change therefore happens on the system clock. The five digit values leave the block on one 20-bit bus, ready for a downstream display multiplexer.

Two mode inputs change only the first stage.

| Mode (`mode_a`, `mode_b`) | Behaviour |
|---|---|
| (0,0) | Plain five-digit counter. |
| (1,1) | Four-digit counter. The first stage is hidden and rounds into the tens. |
| (1,0) | Four-digit counter. The first stage shows a half unit. |
| (0,1) | Test mode. The count edge drives several stages directly, so long chains can be exercised in few edges. |

A master clear empties every stage and raises the carry output. The carry output also marks every wrap of the full chain back to zero, which is how several counters are cascaded.

Top module: `bcd5_mode_counter`

## Requirements
- R1: Every stage holds a value from 0 to 9. `digits[3:0]` is the displayed first stage. `digits[7:4]`, `digits[11:8]`, `digits[15:12]` and `digits[19:16]` are tens, hundreds, thousands and ten-thousands.
- R2: One rising edge of `count_clk` is one count event, and its effect appears after the third rising edge of `clk` that follows it. Holding `count_clk` high produces no further events.
- R3: In mode (0,0) the first stage is shown as counted, and the tens stage advances when the first stage wraps from 9 to 0.
- R4: In mode (1,1) `digits[3:0]` reads 0. The first stage still counts internally, and the tens stage advances when it moves from 4 to 5.
- R5: In mode (1,0) `digits[3:0]` reads 5 while the internal first-stage value is 3 to 7, and reads 0 otherwise. The tens stage advances when the first stage moves from 7 to 8.
- R6: In mode (0,1) `digits[3:0]` reads 0. The first, tens and thousands stages each advance on every count event. Hundreds advances when tens wraps, and ten-thousands advances when thousands wraps.
- R7: `carry_out` rises on the count event that leaves all five internal stage values at zero. It stays high until the next count event.
- R8: While `master_clr` is high, all stages clear to 0 and `carry_out` is 1, even if a count event occurs. After release, `carry_out` stays 1 until the next count event.
- R9: Asynchronous active-low `rst_n` clears all stages and drives `carry_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| count_clk | input | 1 | Count clock, asynchronous; rising edges are counted |
| mode_a | input | 1 | First-stage mode select, bit A |
| mode_b | input | 1 | First-stage mode select, bit B |
| master_clr | input | 1 | Synchronous master clear, active high |
| digits | output | 20 | Five 4-bit decimal digits, units in bits 3:0 |
| carry_out | output | 1 | Full-chain wrap or clear indicator |

## Verification
A count event shows at the outputs after the third rising `clk` edge that follows the `count_clk` rise. Each bench pulse therefore holds `count_clk` high for four system cycles and low for three, and all sampling is done on falling edges. A master clear shows one edge after it is applied, so its check is made at the next falling edge. Full-chain wraps are reached within a hundred events by using test mode.

// File: rtl/bcd5_mode_counter.sv
module bcd5_mode_counter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        count_clk,
  input  logic        mode_a,
  input  logic        mode_b,
  input  logic        master_clr,
  output logic [19:0] digits,
  output logic        carry_out
);
  localparam int NDEC = 5;
  localparam int SW   = SYNC_STAGES + 1;

  logic [SW-1:0]   sync_q;
  logic            tick;
  logic [3:0]      cnt [NDEC];
  logic [3:0]      nxt [NDEC];
  logic [NDEC-1:0] inc, cy, nz;
  logic            test_m, all_zero_nxt, all_zero_now;
  logic [3:0]      shown0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SW-2:0], count_clk};

  assign tick   = sync_q[SW-2] & ~sync_q[SW-1];
  assign test_m = ~mode_a & mode_b;

  always_comb begin
    inc[0] = tick;
    case ({mode_a, mode_b})
      2'b00:   cy[0] = tick && cnt[0] == 4'd9;
      2'b11:   cy[0] = tick && cnt[0] == 4'd4;
      2'b10:   cy[0] = tick && cnt[0] == 4'd7;
      default: cy[0] = 1'b0;
    endcase
  end

  genvar i;
  generate
    for (i = 1; i < NDEC; i++) begin : g_upper
      assign inc[i] = (test_m && (i == 1 || i == 3)) ? tick : cy[i-1];
      assign cy[i]  = inc[i] && cnt[i] == 4'd9;
    end
    for (i = 0; i < NDEC; i++) begin : g_dec
      assign nxt[i] = inc[i] ? ((cnt[i] == 4'd9) ? 4'd0 : cnt[i] + 4'd1) : cnt[i];
      assign nz[i]  = (nxt[i] == 4'd0);
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)          cnt[i] <= '0;
        else if (master_clr) cnt[i] <= '0;
        else                 cnt[i] <= nxt[i];
      p_range_r1: assert property (@(posedge clk) disable iff (!rst_n) cnt[i] <= 4'd9);
    end
  endgenerate

  assign all_zero_nxt = &nz;
  assign all_zero_now = (cnt[0] == 0) && (cnt[1] == 0) && (cnt[2] == 0) &&
                        (cnt[3] == 0) && (cnt[4] == 0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          carry_out <= 1'b0;
    else if (master_clr) carry_out <= 1'b1;
    else if (tick)       carry_out <= all_zero_nxt;

  always_comb
    case ({mode_a, mode_b})
      2'b00:   shown0 = cnt[0];
      2'b10:   shown0 = (cnt[0] >= 4'd3 && cnt[0] <= 4'd7) ? 4'd5 : 4'd0;
      default: shown0 = 4'd0;
    endcase

  assign digits = {cnt[4], cnt[3], cnt[2], cnt[1], shown0};

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !master_clr) |=> (!$stable({mode_a, mode_b}) || $stable(digits)));
  p_inhibit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_b |-> digits[3:0] == 4'd0);
  p_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a && !mode_b) |-> (digits[3:0] == 4'd0 || digits[3:0] == 4'd5));
  p_carry_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |-> all_zero_now);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    master_clr |=> (digits == 20'd0 && carry_out));
endmodule

// File: tb/tb_bcd5_mode_counter.sv
module tb_bcd5_mode_counter;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, count_clk = 0, mode_a = 0, mode_b = 0, master_clr = 0;
  logic [19:0] digits;
  logic carry_out;
  int n_checks = 0, n_fail = 0;

  bcd5_mode_counter dut (.clk(clk), .rst_n(rst_n), .count_clk(count_clk), .mode_a(mode_a),
    .mode_b(mode_b), .master_clr(master_clr), .digits(digits), .carry_out(carry_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse(input int hold = 4);
    @(negedge clk) count_clk = 1;
    repeat (hold) @(negedge clk);
    count_clk = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_with(input logic a, input logic b);
    @(negedge clk) begin mode_a = a; mode_b = b; master_clr = 1; end
    @(negedge clk) master_clr = 0;
  endtask

  task automatic t_reset;
    check("R9 digits after reset", digits, 20'h0);
    check("R9 carry after reset", {19'b0, carry_out}, 20'h0);
  endtask

  task automatic t_normal;
    clear_with(0, 0);
    for (int k = 1; k <= 9; k++) pulse();
    check("R3 units at nine", digits, 20'h00009);
    pulse();
    check("R3 tens after 9->0", digits, 20'h00010);
    pulse(12);
    check("R2 long high counts once", digits, 20'h00011);
    check("R1 digit layout", digits, 20'h00011);
  endtask

  task automatic t_clear;
    clear_with(0, 0);
    check("R8 clear digits", digits, 20'h0);
    check("R8 clear carry", {19'b0, carry_out}, 20'h1);
    pulse();
    check("R7 carry drops on next event", {19'b0, carry_out}, 20'h0);
    check("R2 one event after clear", digits, 20'h00001);
    @(negedge clk) master_clr = 1;
    pulse();
    master_clr = 0;
    @(negedge clk);
    check("R8 clear beats event", digits, 20'h0);
    check("R8 carry held after clear", {19'b0, carry_out}, 20'h1);
  endtask

  task automatic t_round;
    clear_with(1, 1);
    for (int k = 1; k <= 4; k++) pulse();
    check("R4 no carry before 4->5", digits, 20'h0);
    pulse();
    check("R4 tens on 4->5", digits, 20'h00010);
    for (int k = 6; k <= 15; k++) pulse();
    check("R4 second rounding carry", digits, 20'h00020);
  endtask

  task automatic t_half;
    clear_with(1, 0);
    for (int k = 1; k <= 10; k++) begin
      logic [3:0] e0;
      logic [3:0] e1;
      pulse();
      e0 = (k % 10 >= 3 && k % 10 <= 7) ? 4'd5 : 4'd0;
      e1 = (k >= 8) ? 4'd1 : 4'd0;
      check($sformatf("R5 half display after %0d", k), digits, {12'h0, e1, e0});
    end
  endtask

  task automatic t_test;
    clear_with(0, 1);
    for (int k = 1; k <= 3; k++) pulse();
    check("R6 direct drive after 3", digits, 20'h03030);
    for (int k = 4; k <= 10; k++) pulse();
    check("R6 ripple after 10", digits, 20'h10100);
    for (int k = 11; k <= 99; k++) pulse();
    check("R7 no carry at 99", {19'b0, carry_out}, 20'h0);
    check("R6 state at 99", digits, 20'h99990);
    pulse();
    check("R7 carry at full wrap", {19'b0, carry_out}, 20'h1);
    check("R7 all zero at wrap", digits, 20'h0);
    pulse();
    check("R7 carry one period only", {19'b0, carry_out}, 20'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_normal();
    t_clear();
    t_round();
    t_half();
    t_test();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule